// File: doc/BRIEF.md
# Frame ECC syndrome classifier

At the end of each configuration-frame readback, this block takes in a 12-bit syndrome word that arrives with a valid strobe. It sorts the outcome into one of four classes: clean frame, correctable error in a frame data bit, correctable error in one of the check bits, or uncorrectable error. The class is decided by the top syndrome bit together with whether the lower eleven bits are zero.

For a correctable error, the lower eleven bits hold an offset-encoded location. Data bits sit at locations 704 and above. A check-bit error is reported as location 640+k, where k is the single set bit of the location field. When the location field is zero, the error is in the top check bit itself, which is location 651. Only data-bit errors lead to a repair action. For these the block raises a one-cycle flip request carrying the 32-bit word index and the bit offset within the frame.

A flip request stays outstanding until it is acknowledged. A syndrome that arrives while a request is outstanding is still classified, but it sets a sticky overrun flag instead of issuing a second flip. Four saturating counters record frames checked, data corrections, check-bit errors and uncorrectable errors.

Top module: `fecc_classifier`

## Requirements
- R1: Classification outputs are registered. They appear in the cycle after `syn_valid` is sampled high, and `out_valid` is high for exactly that one cycle per strobe.
- R2: A syndrome with bit 11 = 0 and bits 10:0 = 0 is classified as clean (`out_class` = 0), with `out_loc` = 0 and no flip request.
- R3: A syndrome with bit 11 = 0 and bits 10:0 nonzero is classified as uncorrectable (`out_class` = 3). The location field is ignored: `out_loc` = 0, `out_bad_loc` = 0, and no flip request is issued.
- R4: A syndrome with bit 11 = 1 whose bits 10:0 are one-hot at position k (k = 0 to 10, so the value 1024 is included) is classified as a check-bit error (`out_class` = 2) with `out_loc` = 640+k. With bit 11 = 1 and bits 10:0 = 0, the class is also 2 and `out_loc` = 651. A check-bit error never raises a flip request.
- R5: A syndrome with bit 11 = 1 whose bits 10:0 are not one-hot and are at least 704 is classified as a data error (`out_class` = 1) with `out_loc` equal to bits 10:0. `flip_req` pulses for one cycle with `flip_word` = (loc-704)>>5 and `flip_bit` = (loc-704)&31.
- R6: A syndrome with bit 11 = 1 whose bits 10:0 are nonzero, not one-hot and below 704 is classified as uncorrectable (`out_class` = 3) with `out_bad_loc` = 1 and no flip request.
- R7: Once a flip has been issued, it stays outstanding until `flip_ack` is sampled high. A syndrome sampled while a flip is outstanding is classified normally but issues no flip, and it sets `overrun`. `overrun` then stays at 1 until `cnt_clear`.
- R8: Each counter increments once per classified syndrome and holds at its all-ones maximum. `cnt_frames` counts every strobe, `cnt_data` counts class 1, `cnt_check` counts class 2 and `cnt_uncorr` counts class 3.
- R9: When `cnt_clear` is sampled high, all four counters and `overrun` are zero in the following cycle.
- R10: After reset, `out_valid`, `flip_req`, `overrun` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| syn_valid | input | 1 | Syndrome strobe |
| syn_word | input | 12 | Syndrome word |
| flip_ack | input | 1 | Acknowledge for the outstanding flip request |
| cnt_clear | input | 1 | Synchronous clear of the counters and the overrun flag |
| out_valid | output | 1 | Classification valid, one cycle |
| out_class | output | 2 | 0 clean, 1 data error, 2 check-bit error, 3 uncorrectable |
| out_loc | output | 11 | Error location (data or 640+k); 0 for clean and uncorrectable |
| out_bad_loc | output | 1 | Uncorrectable because of an invalid location |
| flip_req | output | 1 | One-cycle flip request |
| flip_word | output | 6 | Word index of the bit to flip |
| flip_bit | output | 5 | Bit offset within the word |
| overrun | output | 1 | Sticky: a strobe arrived while a flip was outstanding |
| cnt_frames | output | CNT_W | Frames checked |
| cnt_data | output | CNT_W | Data-bit errors |
| cnt_check | output | CNT_W | Check-bit errors |
| cnt_uncorr | output | CNT_W | Uncorrectable errors |

## Verification
The bench drives syndromes that hit each quadrant of the top bit against a zero or nonzero location field. These separate clean, uncorrectable, the top-check-bit case and correctable errors. Within the correctable space, it uses one-hot values at the lowest and highest positions (1024 checks that one-hot takes priority over the data range), data locations at 704, in the middle and at 2047 to confirm the word and bit split, and a low, non-one-hot value that must be rejected. A second data syndrome sent without an acknowledge shows flip suppression and the sticky overrun. A clear followed by a run of more strobes than a narrow counter can hold shows zeroing and saturation.

// File: rtl/fecc_pkg.sv
package fecc_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_DATA   = 2'd1,
    CLS_CHECK  = 2'd2,
    CLS_UNCORR = 2'd3
  } fecc_class_e;

  localparam int NUM_CNT = 4;
endpackage

// File: rtl/fecc_rst_sync.sv
module fecc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end

  assign rst_q = stage[1];
endmodule

// File: rtl/fecc_decode.sv
module fecc_decode
  import fecc_pkg::*;
#(
  parameter  int SYN_W      = 12,
  parameter  int DATA_BASE  = 704,
  parameter  int CHECK_BASE = 640,
  parameter  int WORD_W     = 32,
  localparam int LOC_W      = SYN_W - 1,
  localparam int OFF_W      = $clog2(WORD_W),
  localparam int IDX_W      = $clog2(((1 << LOC_W) - DATA_BASE + WORD_W - 1) / WORD_W)
) (
  input  logic [SYN_W-1:0] syn,
  output fecc_class_e      cls,
  output logic [LOC_W-1:0] loc,
  output logic             bad_loc,
  output logic [IDX_W-1:0] word_idx,
  output logic [OFF_W-1:0] bit_off
);
  logic             top_bit;
  logic [LOC_W-1:0] field;
  logic [LOC_W-1:0] rel;
  logic             one_hot;
  logic             in_data;
  int               hot_pos;

  assign top_bit = syn[SYN_W-1];
  assign field   = syn[LOC_W-1:0];
  assign rel     = field - LOC_W'(DATA_BASE);
  assign one_hot = $onehot(field);
  assign in_data = (field >= LOC_W'(DATA_BASE));

  assign word_idx = IDX_W'(rel >> OFF_W);
  assign bit_off  = rel[OFF_W-1:0];

  always_comb begin
    hot_pos = 0;
    for (int i = 0; i < LOC_W; i++) begin
      if (field[i]) hot_pos = i;
    end
  end

  always_comb begin
    cls     = CLS_CLEAN;
    loc     = '0;
    bad_loc = 1'b0;
    if (!top_bit) begin
      if (field != '0) cls = CLS_UNCORR;
    end else if (field == '0) begin
      cls = CLS_CHECK;
      loc = LOC_W'(CHECK_BASE + LOC_W);
    end else if (one_hot) begin
      cls = CLS_CHECK;
      loc = LOC_W'(CHECK_BASE + hot_pos);
    end else if (in_data) begin
      cls = CLS_DATA;
      loc = field;
    end else begin
      cls     = CLS_UNCORR;
      bad_loc = 1'b1;
    end
  end
endmodule

// File: rtl/fecc_sat_counter.sv
module fecc_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_nxt;

  always_comb begin
    count_nxt = count;
    if (clr)                      count_nxt = '0;
    else if (inc && (count != '1)) count_nxt = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end
endmodule

// File: rtl/fecc_classifier.sv
module fecc_classifier
  import fecc_pkg::*;
#(
  parameter  int SYN_W      = 12,
  parameter  int DATA_BASE  = 704,
  parameter  int CHECK_BASE = 640,
  parameter  int WORD_W     = 32,
  parameter  int CNT_W      = 16,
  localparam int LOC_W      = SYN_W - 1,
  localparam int OFF_W      = $clog2(WORD_W),
  localparam int IDX_W      = $clog2(((1 << LOC_W) - DATA_BASE + WORD_W - 1) / WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             syn_valid,
  input  logic [SYN_W-1:0] syn_word,
  input  logic             flip_ack,
  input  logic             cnt_clear,
  output logic             out_valid,
  output logic [1:0]       out_class,
  output logic [LOC_W-1:0] out_loc,
  output logic             out_bad_loc,
  output logic             flip_req,
  output logic [IDX_W-1:0] flip_word,
  output logic [OFF_W-1:0] flip_bit,
  output logic             overrun,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_data,
  output logic [CNT_W-1:0] cnt_check,
  output logic [CNT_W-1:0] cnt_uncorr
);
  logic rst_q;

  fecc_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  fecc_class_e      dec_cls;
  logic [LOC_W-1:0] dec_loc;
  logic             dec_bad;
  logic [IDX_W-1:0] dec_word;
  logic [OFF_W-1:0] dec_bit;

  fecc_decode #(
    .SYN_W      (SYN_W),
    .DATA_BASE  (DATA_BASE),
    .CHECK_BASE (CHECK_BASE),
    .WORD_W     (WORD_W)
  ) u_dec (
    .syn      (syn_word),
    .cls      (dec_cls),
    .loc      (dec_loc),
    .bad_loc  (dec_bad),
    .word_idx (dec_word),
    .bit_off  (dec_bit)
  );

  // flip handshake state
  logic pending, pending_nxt;
  logic overrun_nxt;
  logic issue;
  logic valid_nxt;
  logic load_en;

  assign load_en   = syn_valid;
  assign valid_nxt = syn_valid;
  assign issue     = syn_valid && (dec_cls == CLS_DATA) && !pending;

  always_comb begin
    pending_nxt = pending;
    if (issue)         pending_nxt = 1'b1;
    else if (flip_ack) pending_nxt = 1'b0;
  end

  always_comb begin
    overrun_nxt = overrun;
    if (cnt_clear)                  overrun_nxt = 1'b0;
    else if (syn_valid && pending)  overrun_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      flip_req  <= 1'b0;
      pending   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
      flip_req  <= issue;
      pending   <= pending_nxt;
      overrun   <= overrun_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_class   <= 2'd0;
      out_loc     <= '0;
      out_bad_loc <= 1'b0;
      flip_word   <= '0;
      flip_bit    <= '0;
    end else if (load_en) begin
      out_class   <= dec_cls;
      out_loc     <= dec_loc;
      out_bad_loc <= dec_bad;
      flip_word   <= dec_word;
      flip_bit    <= dec_bit;
    end
  end

  // event counters
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  assign cnt_inc[0] = syn_valid;
  assign cnt_inc[1] = syn_valid && (dec_cls == CLS_DATA);
  assign cnt_inc[2] = syn_valid && (dec_cls == CLS_CHECK);
  assign cnt_inc[3] = syn_valid && (dec_cls == CLS_UNCORR);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    fecc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_q),
      .clr   (cnt_clear),
      .inc   (cnt_inc[g]),
      .count (cnt_val[g])
    );
  end

  assign cnt_frames = cnt_val[0];
  assign cnt_data   = cnt_val[1];
  assign cnt_check  = cnt_val[2];
  assign cnt_uncorr = cnt_val[3];
endmodule

// File: rtl/fecc_classifier_chk.sv
module fecc_classifier_chk
  import fecc_pkg::*;
#(
  parameter int LOC_W = 11,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_q,
  input logic             syn_valid,
  input logic             cnt_clear,
  input logic             out_valid,
  input logic [1:0]       out_class,
  input logic [LOC_W-1:0] out_loc,
  input logic             out_bad_loc,
  input logic             flip_req,
  input logic             overrun,
  input logic [CNT_W-1:0] cnt_frames
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_q)
    syn_valid |=> out_valid);

  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_q)
    !syn_valid |=> !out_valid);

  a_r3_uncorr_loc_zero: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_class == CLS_UNCORR) |-> (out_loc == '0));

  a_r4_check_no_flip: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_class == CLS_CHECK) |-> !flip_req);

  a_r5_flip_only_data: assert property (@(posedge clk) disable iff (!rst_q)
    flip_req |-> (out_valid && out_class == CLS_DATA));

  a_r6_bad_loc_uncorr: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_bad_loc) |-> (out_class == CLS_UNCORR));

  a_r7_single_flip: assert property (@(posedge clk) disable iff (!rst_q)
    flip_req |=> !flip_req);

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (overrun && !cnt_clear) |=> overrun);

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_q)
    ((cnt_frames == '1) && !cnt_clear) |=> (cnt_frames == '1));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_clear |=> (cnt_frames == '0 && !overrun));
endmodule

bind fecc_classifier fecc_classifier_chk #(.LOC_W(LOC_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .syn_valid   (syn_valid),
  .cnt_clear   (cnt_clear),
  .out_valid   (out_valid),
  .out_class   (out_class),
  .out_loc     (out_loc),
  .out_bad_loc (out_bad_loc),
  .flip_req    (flip_req),
  .overrun     (overrun),
  .cnt_frames  (cnt_frames)
);

// File: tb/fecc_classifier_bench.sv
module fecc_classifier_bench;
  localparam int CW  = 4;
  localparam int MAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          syn_valid = 1'b0;
  logic [11:0]   syn_word = '0;
  logic          flip_ack = 1'b0;
  logic          cnt_clear = 1'b0;
  logic          out_valid;
  logic [1:0]    out_class;
  logic [10:0]   out_loc;
  logic          out_bad_loc;
  logic          flip_req;
  logic [5:0]    flip_word;
  logic [4:0]    flip_bit;
  logic          overrun;
  logic [CW-1:0] cnt_frames, cnt_data, cnt_check, cnt_uncorr;

  int n_checks = 0;
  int n_errors = 0;
  int e_frames = 0, e_data = 0, e_check = 0, e_uncorr = 0;
  logic e_pending = 1'b0;

  always #2 clk = ~clk;

  fecc_classifier #(.CNT_W(CW)) u_fecc_classifier (
    .clk(clk), .rst_n(rst_n), .syn_valid(syn_valid), .syn_word(syn_word),
    .flip_ack(flip_ack), .cnt_clear(cnt_clear), .out_valid(out_valid),
    .out_class(out_class), .out_loc(out_loc), .out_bad_loc(out_bad_loc),
    .flip_req(flip_req), .flip_word(flip_word), .flip_bit(flip_bit),
    .overrun(overrun), .cnt_frames(cnt_frames), .cnt_data(cnt_data),
    .cnt_check(cnt_check), .cnt_uncorr(cnt_uncorr)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v >= MAX) ? MAX : v + 1;
  endfunction

  // expected classification derived from the requirements
  task automatic expect_of(input logic [11:0] w, output int cls, output int loc,
                           output int bad);
    int low;
    bit oh;
    low = int'(w[10:0]);
    oh  = (low != 0) && ((low & (low - 1)) == 0);
    bad = 0;
    loc = 0;
    if (!w[11]) cls = (low == 0) ? 0 : 3;
    else if (low == 0) begin cls = 2; loc = 651; end
    else if (oh) begin
      cls = 2;
      for (int i = 0; i < 11; i++) if (low == (1 << i)) loc = 640 + i;
    end else if (low >= 704) begin cls = 1; loc = low; end
    else begin cls = 3; bad = 1; end
  endtask

  task automatic send(input string tag, input logic [11:0] w);
    int cls, loc, bad, exp_flip;
    expect_of(w, cls, loc, bad);
    exp_flip = (cls == 1 && !e_pending) ? 1 : 0;
    @(negedge clk);
    syn_word  = w;
    syn_valid = 1'b1;
    @(negedge clk);
    syn_valid = 1'b0;
    e_frames = sat(e_frames);
    if (cls == 1) e_data = sat(e_data);
    if (cls == 2) e_check = sat(e_check);
    if (cls == 3) e_uncorr = sat(e_uncorr);
    check_eq({tag, " R1 out_valid"}, int'(out_valid), 1);
    check_eq({tag, " class"}, int'(out_class), cls);
    check_eq({tag, " loc"}, int'(out_loc), (cls == 1 || cls == 2) ? loc : 0);
    check_eq({tag, " R6 bad_loc"}, int'(out_bad_loc), bad);
    check_eq({tag, " R5 flip_req"}, int'(flip_req), exp_flip);
    if (exp_flip == 1) begin
      check_eq({tag, " R5 flip_word"}, int'(flip_word), (loc - 704) >> 5);
      check_eq({tag, " R5 flip_bit"}, int'(flip_bit), (loc - 704) & 31);
      e_pending = 1'b1;
    end
    @(negedge clk);
    check_eq({tag, " R1 valid one cycle"}, int'(out_valid), 0);
    check_eq({tag, " R5 flip one cycle"}, int'(flip_req), 0);
  endtask

  task automatic ack();
    flip_ack = 1'b1;
    @(negedge clk);
    flip_ack = 1'b0;
    e_pending = 1'b0;
  endtask

  task automatic check_counts(input string tag);
    check_eq({tag, " R8 cnt_frames"}, int'(cnt_frames), e_frames);
    check_eq({tag, " R8 cnt_data"}, int'(cnt_data), e_data);
    check_eq({tag, " R8 cnt_check"}, int'(cnt_check), e_check);
    check_eq({tag, " R8 cnt_uncorr"}, int'(cnt_uncorr), e_uncorr);
  endtask

  task automatic t_reset();
    check_eq("R10 out_valid", int'(out_valid), 0);
    check_eq("R10 flip_req", int'(flip_req), 0);
    check_eq("R10 overrun", int'(overrun), 0);
    check_counts("R10");
  endtask

  task automatic t_clean();
    send("R2 clean", 12'h000);
  endtask

  task automatic t_uncorr();
    send("R3 uncorr", 12'h005);
    send("R3 uncorr big", 12'h7FF);
    check_counts("R3");
  endtask

  task automatic t_check_bits();
    send("R4 check k0", 12'h801);
    send("R4 check k10", 12'hC00);
    send("R4 check top", 12'h800);
    check_counts("R4");
  endtask

  task automatic t_data();
    send("R5 data first", 12'h800 | 12'd704);
    ack();
    send("R5 data mid", 12'h800 | 12'd1000);
    ack();
    send("R5 data last", 12'hFFF);
    ack();
    check_counts("R5");
  endtask

  task automatic t_invalid();
    send("R6 invalid", 12'h803);
    send("R6 invalid high", 12'h800 | 12'd703);
    check_counts("R6");
  endtask

  task automatic t_overrun();
    check_eq("R7 overrun before", int'(overrun), 0);
    send("R7 first", 12'h800 | 12'd900);
    send("R7 suppressed", 12'h800 | 12'd901);
    check_eq("R7 overrun set", int'(overrun), 1);
    ack();
    send("R7 after ack", 12'h800 | 12'd902);
    ack();
    check_eq("R7 overrun sticky", int'(overrun), 1);
    check_counts("R7");
  endtask

  task automatic t_clear();
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    e_frames = 0; e_data = 0; e_check = 0; e_uncorr = 0;
    check_counts("R9 clear");
    check_eq("R9 overrun cleared", int'(overrun), 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < MAX + 5; i++) send("R8 sat", 12'h000);
    check_eq("R8 saturated", int'(cnt_frames), MAX);
    check_counts("R8 sat");
  endtask

  initial begin
    #200000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean();
    t_uncorr();
    t_check_bits();
    t_data();
    t_invalid();
    t_overrun();
    t_clear();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule